// File: doc/BRIEF.md
# Health Test Limit Register Bank

This block stores the acceptance limits of a single statistical health test and records the extreme values of that test's score. It keeps an upper limit and a lower limit. Each is a 32-bit word built from two 16-bit halves: the lower half serves normal (compliance) operation and the upper half serves bypass operation. Software may only tighten a limit. An upper half accepts a strictly smaller value, and a lower half accepts a strictly larger value. Each half is judged on its own.

Writes to the limits are allowed only while the surrounding module is disabled and a software update-permission bit is still set. That bit is cleared by writing zero to it, and nothing sets it again before reset. A three-state controller tracks this:
- OPEN: module enable is the false encoding and the permission bit is set. Limit writes are accepted here.
- ACTIVE: module enable is any other value and the permission bit is set.
- SEALED: the permission bit has been cleared. This state is terminal.

Transitions are as follows. OPEN goes to ACTIVE when the enable leaves the false encoding, and ACTIVE goes back to OPEN when it returns. Either state goes to SEALED on a write of zero to the permission bit.

Scores arrive with a mode flag and a window-done strobe. On each strobe the block updates the high and low watermarks of the active mode. In the same cycle it flags whether the score broke the active mode's limits.

Top module: `health_limit_bank`

## Requirements
- R1: After reset the upper limit reads 0xFFFF_FFFF, the lower limit 0x0000_0000, the high watermark 0x0000_0000, the low watermark 0xFFFF_FFFF, the permission bit 1 and the alert 0.
- R2: In the upper-limit word, bits 15:0 are the normal field and bits 31:16 are the bypass field. A written field is stored only if the new value is strictly less than the stored value.
- R3: In the lower-limit word, the normal and bypass fields sit at the same bit positions. A written field is stored only if the new value is strictly greater than the stored value.
- R4: The two fields of one write are judged independently, so one may be stored while the other is rejected.
- R5: A limit write has no effect unless `wr_open_o` is high in the cycle of the write.
- R6: `wr_open_o` is high exactly when the state is OPEN. The state follows the module enable one cycle later, with false encoded as 4'b1001.
- R7: A write of 0 to the permission bit clears `upd_perm_o` from the next cycle onward. A write of 1 never sets it.
- R8: A module-enable value other than 4'b0110 (true) or 4'b1001 (false) sets `cfg_alert_o` from the next cycle. It stays set until reset.
- R9: On a strobe with `score_byp_i`=0 the normal watermark halves (bits 15:0) are updated, and with `score_byp_i`=1 the bypass halves (bits 31:16) are updated. The high watermark takes the maximum of itself and the score, and the low watermark takes the minimum. The new values are visible the next cycle. Without a strobe the watermarks do not change.
- R10: During a strobe, `fail_hi_o` is high when the score is strictly above the active mode's upper limit. `fail_lo_o` is high when the score is strictly below the active mode's lower limit. Both are low without a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mod_en_i | input | 4 | Module enable, multi-bit boolean |
| lim_we_i | input | 1 | Limit write strobe |
| lim_sel_i | input | 1 | 0 selects the upper limit, 1 the lower limit |
| lim_wdata_i | input | 32 | Limit write data (bypass field high, normal field low) |
| perm_we_i | input | 1 | Permission bit write strobe |
| perm_wdata_i | input | 1 | Permission bit write value |
| score_i | input | 16 | Test score |
| score_byp_i | input | 1 | Score belongs to bypass mode |
| score_done_i | input | 1 | Window-done strobe |
| lim_hi_o | output | 32 | Stored upper limit |
| lim_lo_o | output | 32 | Stored lower limit |
| wm_hi_o | output | 32 | High watermarks |
| wm_lo_o | output | 32 | Low watermarks |
| wr_open_o | output | 1 | Limit writes currently allowed |
| upd_perm_o | output | 1 | Permission bit |
| cfg_alert_o | output | 1 | Sticky invalid-enable alert |
| fail_hi_o | output | 1 | Score above upper limit |
| fail_lo_o | output | 1 | Score below lower limit |

## Verification
The bench sends mixed writes in which one half loosens and the other tightens. A bank that compares the whole word, or that uses the wrong sign, would store both halves or neither. It also writes an equal value, which a bank with a non-strict compare would accept silently. Writes are then tried in ACTIVE and SEALED, and the permission bit is written with 1 after sealing. A leaky gate would let those writes move the limits, and a reversible lock would reopen. Finally it feeds scores in both modes, with and without the strobe. A swapped mode index would update the wrong watermark half or test against the wrong limits.

// File: rtl/health_limit_pkg.sv
package health_limit_pkg;
    localparam logic [3:0] MB4_TRUE  = 4'b0110;
    localparam logic [3:0] MB4_FALSE = 4'b1001;

    typedef enum logic [1:0] {
        ST_OPEN   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_SEALED = 2'd2
    } lock_state_e;
endpackage

// File: rtl/hl_lock_fsm.sv
module hl_lock_fsm
    import health_limit_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic [3:0] mod_en_i,
    input  logic       perm_we_i,
    input  logic       perm_wdata_i,
    output logic       wr_open_o,
    output logic       upd_perm_o,
    output logic       cfg_alert_o
);
    lock_state_e state_q, state_d;
    logic        alert_q;
    logic        en_is_false, en_invalid, perm_clear;

    assign en_is_false = (mod_en_i == MB4_FALSE);
    assign en_invalid  = (mod_en_i != MB4_FALSE) && (mod_en_i != MB4_TRUE);
    assign perm_clear  = perm_we_i && !perm_wdata_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OPEN: begin
                if (perm_clear)        state_d = ST_SEALED;
                else if (!en_is_false) state_d = ST_ACTIVE;
            end
            ST_ACTIVE: begin
                if (perm_clear)        state_d = ST_SEALED;
                else if (en_is_false)  state_d = ST_OPEN;
            end
            ST_SEALED: state_d = ST_SEALED;
            default:   state_d = ST_SEALED;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_OPEN;
        else         state_q <= state_d;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)         alert_q <= 1'b0;
        else if (en_invalid) alert_q <= 1'b1;
    end

    always_comb begin
        wr_open_o   = (state_q == ST_OPEN);
        upd_perm_o  = (state_q != ST_SEALED);
        cfg_alert_o = alert_q;
    end

    AST_SEALED_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !upd_perm_o |=> !upd_perm_o); // R7
    AST_ALERT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_alert_o |=> cfg_alert_o); // R8
    AST_BAD_EN_ALERTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        en_invalid |=> cfg_alert_o); // R8
    AST_OPEN_NEEDS_PERM: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_open_o |-> upd_perm_o); // R6
endmodule

// File: rtl/hl_limit_field.sv
module hl_limit_field #(
    parameter int unsigned FW      = 16,
    parameter bit          IS_UPPER = 1'b1
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          we_i,
    input  logic [FW-1:0] wdata_i,
    output logic [FW-1:0] q_o
);
    logic [FW-1:0] q;
    logic          tighter;

    generate
        if (IS_UPPER) begin : g_upper
            assign tighter = (wdata_i < q);
        end else begin : g_lower
            assign tighter = (wdata_i > q);
        end
    endgenerate

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)              q <= IS_UPPER ? {FW{1'b1}} : {FW{1'b0}};
        else if (we_i && tighter) q <= wdata_i;
    end

    assign q_o = q;

    generate
        if (IS_UPPER) begin : g_chk_up
            AST_UPPER_NEVER_RISES: assert property (@(posedge clk_i) disable iff (!rst_ni)
                rst_ni |=> (q <= $past(q))); // R2
        end else begin : g_chk_lo
            AST_LOWER_NEVER_FALLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
                rst_ni |=> (q >= $past(q))); // R3
        end
    endgenerate
endmodule

// File: rtl/hl_watermark.sv
module hl_watermark #(
    parameter int unsigned FW      = 16,
    parameter bit          IS_HIGH = 1'b1
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          upd_i,
    input  logic [FW-1:0] score_i,
    output logic [FW-1:0] q_o
);
    logic [FW-1:0] q;
    logic          beyond;

    generate
        if (IS_HIGH) begin : g_high
            assign beyond = (score_i > q);
        end else begin : g_low
            assign beyond = (score_i < q);
        end
    endgenerate

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)              q <= IS_HIGH ? {FW{1'b0}} : {FW{1'b1}};
        else if (upd_i && beyond) q <= score_i;
    end

    assign q_o = q;

    AST_WM_HOLDS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !upd_i |=> $stable(q)); // R9
endmodule

// File: rtl/health_limit_bank.sv
module health_limit_bank
    import health_limit_pkg::*;
#(
    parameter int unsigned FW = 16
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [3:0]      mod_en_i,
    input  logic            lim_we_i,
    input  logic            lim_sel_i,
    input  logic [2*FW-1:0] lim_wdata_i,
    input  logic            perm_we_i,
    input  logic            perm_wdata_i,
    input  logic [FW-1:0]   score_i,
    input  logic            score_byp_i,
    input  logic            score_done_i,
    output logic [2*FW-1:0] lim_hi_o,
    output logic [2*FW-1:0] lim_lo_o,
    output logic [2*FW-1:0] wm_hi_o,
    output logic [2*FW-1:0] wm_lo_o,
    output logic            wr_open_o,
    output logic            upd_perm_o,
    output logic            cfg_alert_o,
    output logic            fail_hi_o,
    output logic            fail_lo_o
);
    localparam int unsigned NMODE = 2;

    logic          we_hi, we_lo;
    logic [FW-1:0] hi_f [NMODE];
    logic [FW-1:0] lo_f [NMODE];
    logic [FW-1:0] wmh_f [NMODE];
    logic [FW-1:0] wml_f [NMODE];
    logic [FW-1:0] act_hi, act_lo;

    hl_lock_fsm u_lock (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .mod_en_i     (mod_en_i),
        .perm_we_i    (perm_we_i),
        .perm_wdata_i (perm_wdata_i),
        .wr_open_o    (wr_open_o),
        .upd_perm_o   (upd_perm_o),
        .cfg_alert_o  (cfg_alert_o)
    );

    assign we_hi = lim_we_i && wr_open_o && !lim_sel_i;
    assign we_lo = lim_we_i && wr_open_o &&  lim_sel_i;

    for (genvar m = 0; m < NMODE; m++) begin : g_mode
        logic upd_m;
        assign upd_m = score_done_i && (score_byp_i == (m == 1));

        hl_limit_field #(.FW(FW), .IS_UPPER(1'b1)) u_hi (
            .clk_i (clk_i), .rst_ni (rst_ni), .we_i (we_hi),
            .wdata_i (lim_wdata_i[m*FW +: FW]), .q_o (hi_f[m])
        );
        hl_limit_field #(.FW(FW), .IS_UPPER(1'b0)) u_lo (
            .clk_i (clk_i), .rst_ni (rst_ni), .we_i (we_lo),
            .wdata_i (lim_wdata_i[m*FW +: FW]), .q_o (lo_f[m])
        );
        hl_watermark #(.FW(FW), .IS_HIGH(1'b1)) u_wmh (
            .clk_i (clk_i), .rst_ni (rst_ni), .upd_i (upd_m),
            .score_i (score_i), .q_o (wmh_f[m])
        );
        hl_watermark #(.FW(FW), .IS_HIGH(1'b0)) u_wml (
            .clk_i (clk_i), .rst_ni (rst_ni), .upd_i (upd_m),
            .score_i (score_i), .q_o (wml_f[m])
        );

        assign lim_hi_o[m*FW +: FW] = hi_f[m];
        assign lim_lo_o[m*FW +: FW] = lo_f[m];
        assign wm_hi_o[m*FW +: FW]  = wmh_f[m];
        assign wm_lo_o[m*FW +: FW]  = wml_f[m];
    end

    assign act_hi = score_byp_i ? hi_f[1] : hi_f[0];
    assign act_lo = score_byp_i ? lo_f[1] : lo_f[0];

    always_comb begin
        fail_hi_o = score_done_i && (score_i > act_hi);
        fail_lo_o = score_done_i && (score_i < act_lo);
    end

    AST_CLOSED_NO_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_open_o |=> ($stable(lim_hi_o) && $stable(lim_lo_o))); // R5
    AST_NO_FAIL_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !score_done_i |-> (!fail_hi_o && !fail_lo_o)); // R10
endmodule

// File: tb/health_limit_bank_bench.sv
`timescale 1ns/1ps
module health_limit_bank_bench;
    localparam int FW = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [3:0]      mod_en = 4'b1001;
    logic            lim_we = 1'b0, lim_sel = 1'b0;
    logic [2*FW-1:0] lim_wdata = '0;
    logic            perm_we = 1'b0, perm_wdata = 1'b0;
    logic [FW-1:0]   score = '0;
    logic            score_byp = 1'b0, score_done = 1'b0;
    logic [2*FW-1:0] lim_hi, lim_lo, wm_hi, wm_lo;
    logic            wr_open, upd_perm, cfg_alert, fail_hi, fail_lo;

    always #2.5 clk = ~clk;

    health_limit_bank #(.FW(FW)) u_health_limit_bank (
        .clk_i (clk), .rst_ni (rst_n), .mod_en_i (mod_en),
        .lim_we_i (lim_we), .lim_sel_i (lim_sel), .lim_wdata_i (lim_wdata),
        .perm_we_i (perm_we), .perm_wdata_i (perm_wdata),
        .score_i (score), .score_byp_i (score_byp), .score_done_i (score_done),
        .lim_hi_o (lim_hi), .lim_lo_o (lim_lo), .wm_hi_o (wm_hi), .wm_lo_o (wm_lo),
        .wr_open_o (wr_open), .upd_perm_o (upd_perm), .cfg_alert_o (cfg_alert),
        .fail_hi_o (fail_hi), .fail_lo_o (fail_lo)
    );

    typedef struct {
        string       tag;
        int          sel;
        logic [31:0] exp;
    } item_t;

    item_t sbq[$];
    int    n_checks = 0;
    int    n_errors = 0;
    bit    finished = 1'b0;

    function automatic logic [31:0] observe(int sel);
        case (sel)
            0: return lim_hi;
            1: return lim_lo;
            2: return wm_hi;
            3: return wm_lo;
            4: return {31'd0, wr_open};
            5: return {31'd0, upd_perm};
            6: return {31'd0, cfg_alert};
            7: return {31'd0, fail_hi};
            default: return {31'd0, fail_lo};
        endcase
    endfunction

    task automatic expect_out(string tag, int sel, logic [31:0] exp);
        item_t it;
        it.tag = tag; it.sel = sel; it.exp = exp;
        sbq.push_back(it);
    endtask

    // monitor: compares queued expectations away from the active edge
    always @(negedge clk) begin
        while (sbq.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it  = sbq.pop_front();
            act = observe(it.sel);
            n_checks++;
            if (act !== it.exp) begin
                n_errors++;
                $display("FAIL %s sel=%0d actual=%h expected=%h", it.tag, it.sel, act, it.exp);
            end
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic wr_limit(logic sel, logic [31:0] d);
        lim_sel = sel; lim_wdata = d; lim_we = 1'b1;
        tick();
        lim_we = 1'b0;
    endtask

    task automatic wr_perm(logic v);
        perm_wdata = v; perm_we = 1'b1;
        tick();
        perm_we = 1'b0;
    endtask

    task automatic set_en(logic [3:0] v);
        mod_en = v;
        tick();
    endtask

    // drive a strobe; check flags in strobe cycle, then release
    task automatic strobe(logic byp, logic [15:0] s, logic eh, logic el, string tag);
        score = s; score_byp = byp; score_done = 1'b1;
        expect_out({tag, " R10 hi"}, 7, {31'd0, eh});
        expect_out({tag, " R10 lo"}, 8, {31'd0, el});
        tick();
        score_done = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_errors++; n_checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        tick();
        // R1 reset state
        expect_out("R1 lim_hi", 0, 32'hFFFF_FFFF);
        expect_out("R1 lim_lo", 1, 32'h0000_0000);
        expect_out("R1 wm_hi", 2, 32'h0000_0000);
        expect_out("R1 wm_lo", 3, 32'hFFFF_FFFF);
        expect_out("R1 perm", 5, 32'd1);
        expect_out("R1 alert", 6, 32'd0);
        expect_out("R6 open at reset", 4, 32'd1);
        tick();

        // R2 upper tightening, field positions
        wr_limit(1'b0, 32'h0200_0100);
        expect_out("R2 upper both tighter", 0, 32'h0200_0100);
        tick();
        // R4 bypass loosens (rejected), normal tightens (stored)
        wr_limit(1'b0, 32'h0300_0080);
        expect_out("R4 upper mixed", 0, 32'h0200_0080);
        tick();
        // R2 equal value rejected
        wr_limit(1'b0, 32'h0200_0080);
        expect_out("R2 upper equal", 0, 32'h0200_0080);
        tick();
        // R3 lower tightening
        wr_limit(1'b1, 32'h0010_0020);
        expect_out("R3 lower both", 1, 32'h0010_0020);
        tick();
        wr_limit(1'b1, 32'h0005_0030);
        expect_out("R4 lower mixed", 1, 32'h0010_0030);
        expect_out("R3 upper untouched by lower write", 0, 32'h0200_0080);
        tick();

        // R10 / R9 scores
        strobe(1'b0, 16'h0081, 1'b1, 1'b0, "normal above");
        expect_out("R9 wm_hi normal", 2, 32'h0000_0081);
        strobe(1'b0, 16'h0010, 1'b0, 1'b1, "normal below");
        expect_out("R9 wm_lo normal", 3, 32'hFFFF_0010);
        strobe(1'b1, 16'h0201, 1'b1, 1'b0, "bypass above");
        strobe(1'b1, 16'h0050, 1'b0, 1'b0, "bypass inside");
        expect_out("R9 wm_hi both", 2, 32'h0201_0081);
        expect_out("R9 wm_lo both", 3, 32'h0050_0010);
        strobe(1'b0, 16'h0080, 1'b0, 1'b0, "normal at limit");
        expect_out("R9 wm_hi no shrink", 2, 32'h0201_0081);
        // R9/R10 no strobe, extreme score
        score = 16'hFFFF; score_byp = 1'b0; score_done = 1'b0;
        expect_out("R10 no strobe hi", 7, 32'd0);
        tick();
        score = 16'h0000;
        tick();
        expect_out("R9 wm_hi idle", 2, 32'h0201_0081);
        expect_out("R9 wm_lo idle", 3, 32'h0050_0010);
        tick();

        // R6 / R5 enable true closes writes
        set_en(4'b0110);
        expect_out("R6 closed when enabled", 4, 32'd0);
        wr_limit(1'b0, 32'h0001_0001);
        expect_out("R5 write while active", 0, 32'h0200_0080);
        expect_out("R8 valid enable no alert", 6, 32'd0);
        set_en(4'b1001);
        expect_out("R6 reopens", 4, 32'd1);
        tick();
        // R8 invalid enable
        set_en(4'b0000);
        expect_out("R8 alert set", 6, 32'd1);
        expect_out("R6 closed on invalid", 4, 32'd0);
        set_en(4'b1001);
        expect_out("R8 alert sticky", 6, 32'd1);
        expect_out("R6 open again", 4, 32'd1);
        tick();

        // R7 permission bit
        wr_perm(1'b1);
        expect_out("R7 write one keeps", 5, 32'd1);
        wr_perm(1'b0);
        expect_out("R7 cleared", 5, 32'd0);
        expect_out("R6 sealed closed", 4, 32'd0);
        wr_limit(1'b1, 32'h0011_0031);
        expect_out("R5 write while sealed", 1, 32'h0010_0030);
        wr_perm(1'b1);
        expect_out("R7 cannot reset", 5, 32'd0);
        tick();
        tick();

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule